// File: doc/BRIEF.md
# Ladder Scan Cycle Engine

This block is a tiny programmable-controller core. It repeats one fixed scan for as long as it runs. At the start of each scan the physical output register takes the output image from the previous scan. The physical inputs are then frozen and copied into an input image register. A hard-wired set of five ladder rungs is evaluated from that image, one rung per clock. Each rung writes its coil bit, and a one-cycle pulse marks the end of the scan.

The rungs use normally open contacts, which conduct on 1, and normally closed contacts, which conduct on 0. They are combined in series (AND) and in parallel branches (OR). One internal relay coil, the run relay, has contacts that later rungs in the same scan read. Because the inputs are sampled into an image and the outputs are refreshed only at the start of the next scan, a result reaches the pins one scan after its inputs were frozen. That delay is intended.

Top module: `plc_scan_engine`

## Requirements
- R1: After reset, each scan takes exactly 9 clocks in this order: output transfer, input freeze, image load, five rung steps, then done. `scan_done_o` is high for exactly one clock per scan, in the clock after the last rung is written.
- R2: Rungs see only the input image loaded at the start of the current scan. A change on `in_i` after the freeze clock has no effect on that scan's results. It takes effect on the next scan.
- R3: `out_o` changes only at the clock edge that ends the output-transfer phase. While `scan_done_o` is high, `out_o` still shows the previous scan's results.
- R4: The run relay is set when the start input (`in_i[0]`, normally open) is 1, or when the relay's own contact is closed. This parallel path is in series with the stop input (`in_i[1]`, normally closed). The relay stays set after start returns to 0, and stop=1 clears it even while start=1.
- R5: `out_o[0]` (lamp) is the normally closed contact of the run relay and `out_o[1]` (motor) is its normally open contact. Both use the relay value written earlier in the same scan.
- R6: `out_o[2]` is 1 exactly when (`in_i[2]` AND `in_i[3]`) OR `in_i[4]`.
- R7: `out_o[3]` is 1 exactly when `in_i[2]`, `in_i[3]` and `in_i[5]` are all 1 and `in_i[1]` is 0.
- R8: While `rst_ni` is low, `out_o`, `scan_done_o`, `scan_cnt_o`, both image registers and the run relay are all 0. After a reset, the lamp turns on in the first scan with stop and start both at 0.
- R9: `scan_cnt_o` increases by one in the clock after each `scan_done_o` pulse, wraps from its maximum value to 0, and holds its value at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | IN_W | Physical input bus |
| out_o | output | 4 | Registered physical outputs |
| scan_done_o | output | 1 | One-clock end-of-scan pulse |
| scan_cnt_o | output | CNT_W | Completed scan count, wraps |

## Verification
The hardest case to produce from the ports is an input that changes after the freeze clock but before the rungs have finished. The stimulus aligns itself to the end-of-scan pulse and counts two clocks to land in the freeze phase. It sets a stop level that the freeze captures, then withdraws that level one clock later, while the scan is still running. The seal-in relay gives the two outcomes different values, so a leak of the live input would leave the motor on. Counter wrap is reached by building the bench with a narrow counter.

// File: rtl/plc_scan_pkg.sv
package plc_scan_pkg;
  typedef enum logic [2:0] {
    PH_OUT    = 3'd0,
    PH_FREEZE = 3'd1,
    PH_LOAD   = 3'd2,
    PH_RUNG   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  localparam int NUM_RUNGS  = 5;
  localparam int RUNG_W     = $clog2(NUM_RUNGS);
  localparam int NUM_RELAYS = 1;
  localparam int NUM_OUTS   = 4;
  localparam int NUM_COILS  = NUM_RELAYS + NUM_OUTS;
  localparam int COIL_W     = $clog2(NUM_COILS);

  // input bit map
  localparam int IN_START  = 0;
  localparam int IN_STOP   = 1;
  localparam int IN_HAND_A = 2;
  localparam int IN_HAND_B = 3;
  localparam int IN_BYPASS = 4;
  localparam int IN_PART   = 5;
  localparam int IN_USED   = 6;

  // coil map: relays first, then physical outputs
  localparam int CL_RUN    = 0;
  localparam int CL_LAMP   = 1;
  localparam int CL_MOTOR  = 2;
  localparam int CL_BRANCH = 3;
  localparam int CL_GUARD  = 4;

  function automatic logic no_c(input logic b);
    return b;
  endfunction

  function automatic logic nc_c(input logic b);
    return ~b;
  endfunction
endpackage

// File: rtl/plc_scan_seq.sv
module plc_scan_seq
  import plc_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output phase_e            phase_o,
  output logic [RUNG_W-1:0] rung_o
);
  localparam logic [RUNG_W-1:0] LAST_RUNG = RUNG_W'(NUM_RUNGS - 1);

  phase_e            phase_q;
  logic [RUNG_W-1:0] rung_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OUT;
      rung_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_OUT:    phase_q <= PH_FREEZE;
        PH_FREEZE: phase_q <= PH_LOAD;
        PH_LOAD: begin
          phase_q <= PH_RUNG;
          rung_q  <= '0;
        end
        PH_RUNG: begin
          if (rung_q == LAST_RUNG) phase_q <= PH_DONE;
          else rung_q <= rung_q + 1'b1;
        end
        PH_DONE:   phase_q <= PH_OUT;
        default:   phase_q <= PH_OUT;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign rung_o  = rung_q;
endmodule

// File: rtl/plc_io_image.sv
module plc_io_image
  import plc_scan_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  phase_e               phase_i,
  input  logic [IN_W-1:0]      in_i,
  input  logic                 coil_we_i,
  input  logic [COIL_W-1:0]    coil_idx_i,
  input  logic                 coil_val_i,
  output logic [IN_W-1:0]      in_img_o,
  output logic [NUM_COILS-1:0] coil_img_o,
  output logic [NUM_OUTS-1:0]  out_o
);
  logic [IN_W-1:0]      frz_q;
  logic [IN_W-1:0]      img_q;
  logic [NUM_COILS-1:0] coil_q;
  logic [NUM_OUTS-1:0]  out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q <= '0;
      img_q <= '0;
      out_q <= '0;
    end else begin
      if (phase_i == PH_OUT)    out_q <= coil_q[NUM_COILS-1:NUM_RELAYS];
      if (phase_i == PH_FREEZE) frz_q <= in_i;
      if (phase_i == PH_LOAD)   img_q <= frz_q;
    end
  end

  for (genvar g = 0; g < NUM_COILS; g++) begin : g_coil
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) coil_q[g] <= 1'b0;
      else if (coil_we_i && coil_idx_i == COIL_W'(g)) coil_q[g] <= coil_val_i;
    end
  end

  assign in_img_o   = img_q;
  assign coil_img_o = coil_q;
  assign out_o      = out_q;
endmodule

// File: rtl/plc_rung_eval.sv
module plc_rung_eval
  import plc_scan_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic [RUNG_W-1:0]    rung_i,
  input  logic [IN_W-1:0]      in_img_i,
  input  logic [NUM_COILS-1:0] coil_img_i,
  output logic [COIL_W-1:0]    coil_idx_o,
  output logic                 coil_val_o
);
  logic run_c, start_c, stop_c, a_c, b_c, byp_c, part_c;

  always_comb begin
    run_c   = coil_img_i[CL_RUN];
    start_c = in_img_i[IN_START];
    stop_c  = in_img_i[IN_STOP];
    a_c     = in_img_i[IN_HAND_A];
    b_c     = in_img_i[IN_HAND_B];
    byp_c   = in_img_i[IN_BYPASS];
    part_c  = in_img_i[IN_PART];
    coil_idx_o = COIL_W'(CL_RUN);
    coil_val_o = 1'b0;
    unique case (rung_i)
      RUNG_W'(0): begin  // seal-in
        coil_idx_o = COIL_W'(CL_RUN);
        coil_val_o = (no_c(start_c) | no_c(run_c)) & nc_c(stop_c);
      end
      RUNG_W'(1): begin
        coil_idx_o = COIL_W'(CL_LAMP);
        coil_val_o = nc_c(run_c);
      end
      RUNG_W'(2): begin
        coil_idx_o = COIL_W'(CL_MOTOR);
        coil_val_o = no_c(run_c);
      end
      RUNG_W'(3): begin
        coil_idx_o = COIL_W'(CL_BRANCH);
        coil_val_o = (no_c(a_c) & no_c(b_c)) | no_c(byp_c);
      end
      RUNG_W'(4): begin
        coil_idx_o = COIL_W'(CL_GUARD);
        coil_val_o = nc_c(stop_c) & no_c(a_c) & no_c(b_c) & no_c(part_c);
      end
      default: begin
        coil_idx_o = COIL_W'(CL_RUN);
        coil_val_o = run_c;
      end
    endcase
  end
endmodule

// File: rtl/plc_scan_counter.sv
module plc_scan_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/plc_scan_engine.sv
module plc_scan_engine
  import plc_scan_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IN_W-1:0]     in_i,
  output logic [NUM_OUTS-1:0] out_o,
  output logic                scan_done_o,
  output logic [CNT_W-1:0]    scan_cnt_o
);
  phase_e               phase;
  logic [RUNG_W-1:0]    rung;
  logic [IN_W-1:0]      in_img;
  logic [NUM_COILS-1:0] coil_img;
  logic [COIL_W-1:0]    coil_idx;
  logic                 coil_val;
  logic                 coil_we;
  logic                 done;

  assign coil_we = (phase == PH_RUNG);
  assign done    = (phase == PH_DONE);

  plc_scan_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .rung_o  (rung)
  );

  plc_io_image #(.IN_W(IN_W)) u_img (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .in_i       (in_i),
    .coil_we_i  (coil_we),
    .coil_idx_i (coil_idx),
    .coil_val_i (coil_val),
    .in_img_o   (in_img),
    .coil_img_o (coil_img),
    .out_o      (out_o)
  );

  plc_rung_eval #(.IN_W(IN_W)) u_eval (
    .rung_i     (rung),
    .in_img_i   (in_img),
    .coil_img_i (coil_img),
    .coil_idx_o (coil_idx),
    .coil_val_o (coil_val)
  );

  plc_scan_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (done),
    .cnt_o  (scan_cnt_o)
  );

  assign scan_done_o = done;
endmodule

// File: rtl/plc_scan_engine_chk.sv
module plc_scan_engine_chk
  import plc_scan_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int CNT_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input phase_e               phase_i,
  input logic [IN_W-1:0]      in_img_i,
  input logic [NUM_OUTS-1:0]  out_i,
  input logic                 done_i,
  input logic [CNT_W-1:0]     cnt_i
);
  p_done_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_to_out_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> phase_i == PH_OUT);

  p_out_to_freeze_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_OUT |=> phase_i == PH_FREEZE);

  p_image_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i != PH_LOAD |=> $stable(in_img_i));

  p_out_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i != PH_OUT |=> $stable(out_i));

  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(cnt_i));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r8: assert (out_i == '0 && cnt_i == '0 && !done_i && in_img_i == '0);
    end
  end
endmodule

bind plc_scan_engine plc_scan_engine_chk #(.IN_W(IN_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .phase_i  (phase),
  .in_img_i (in_img),
  .out_i    (out_o),
  .done_i   (scan_done_o),
  .cnt_i    (scan_cnt_o)
);

// File: tb/plc_scan_engine_tb.sv
module plc_scan_engine_tb_top;
  localparam int IN_W  = 8;
  localparam int CNT_W = 4;
  localparam int NVEC  = 12;

  // {in_i, expected out_o = {guard, branch, motor, lamp}}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h00, 4'b0001},  // R5 idle: lamp on
    {8'h01, 4'b0010},  // R4 start sets relay, R5 motor same scan
    {8'h00, 4'b0010},  // R4 seal-in holds
    {8'h02, 4'b0001},  // R4 stop clears
    {8'h03, 4'b0001},  // R4 stop dominates start
    {8'h0C, 4'b0101},  // R6 series branch
    {8'h2C, 4'b1101},  // R7 guard all true
    {8'h2E, 4'b0101},  // R7 NC stop breaks guard
    {8'h10, 4'b0101},  // R6 bypass branch alone
    {8'h24, 4'b0001},  // R6/R7 single hand
    {8'h2D, 4'b1110},  // R4..R7 combined
    {8'h00, 4'b0010}   // R4 seal-in after combined
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IN_W-1:0]  in_i = '0;
  logic [3:0]       out_o;
  logic             scan_done_o;
  logic [CNT_W-1:0] scan_cnt_o;

  int checks = 0;
  int errors = 0;
  int scans  = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  plc_scan_engine #(.IN_W(IN_W), .CNT_W(CNT_W)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_i        (in_i),
    .out_o       (out_o),
    .scan_done_o (scan_done_o),
    .scan_cnt_o  (scan_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    do @(negedge clk_i); while (!scan_done_o);
    scans++;
  endtask

  // from the done clock to just after the output-transfer edge
  task automatic see_out();
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    logic [3:0] prev;
    int gap;
    repeat (3) @(negedge clk_i);
    chk(out_o == 4'h0, "R8 out in reset", int'(out_o), 0);
    chk(scan_done_o == 1'b0, "R8 done in reset", int'(scan_done_o), 0);
    chk(scan_cnt_o == '0, "R8 count in reset", int'(scan_cnt_o), 0);
    rst_ni = 1'b1;

    prev = 4'h0;
    for (int i = 0; i < NVEC; i++) begin
      in_i = VEC[i][11:4];
      wait_done();
      chk(out_o == prev, "R3 stale output at done", int'(out_o), int'(prev));
      see_out();
      chk(out_o == VEC[i][3:0], "R4/R5/R6/R7 vector", int'(out_o), int'(VEC[i][3:0]));
      prev = VEC[i][3:0];
    end

    // R1 scan period
    wait_done();
    gap = 0;
    do begin
      @(negedge clk_i);
      gap++;
    end while (!scan_done_o);
    scans++;
    chk(gap == 9, "R1 clocks per scan", gap, 9);
    @(negedge clk_i);
    chk(scan_done_o == 1'b0, "R1 done one clock", int'(scan_done_o), 0);

    // R2 mid-scan change: relay is set, freeze stop then drop it
    do @(negedge clk_i); while (!scan_done_o);
    scans++;
    see_out();  // now in freeze phase
    in_i = 8'h02;
    @(negedge clk_i);
    in_i = 8'h00;
    wait_done();
    see_out();
    chk(out_o == 4'b0001, "R2 snapshot used", int'(out_o), 1);
    wait_done();
    see_out();
    chk(out_o == 4'b0001, "R2 next scan", int'(out_o), 1);

    // R9 count and wrap
    chk(int'(scan_cnt_o) == scans % 16, "R9 count", int'(scan_cnt_o), scans % 16);
    while (scans < 32) begin
      wait_done();
      @(negedge clk_i);
      if (scans == 16 || scans == 32)
        chk(scan_cnt_o == '0, "R9 wrap to zero", int'(scan_cnt_o), 0);
    end

    // R8 reset mid run clears relay
    in_i = 8'h01;
    wait_done();
    see_out();
    chk(out_o == 4'b0010, "R4 set before reset", int'(out_o), 2);
    rst_ni = 1'b0;
    in_i = 8'h00;
    @(negedge clk_i);
    chk(out_o == 4'h0, "R8 out cleared", int'(out_o), 0);
    chk(scan_cnt_o == '0, "R8 count cleared", int'(scan_cnt_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait_done();
    see_out();
    chk(out_o == 4'b0001, "R8 relay cleared", int'(out_o), 1);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule